// File: doc/BRIEF.md
# Scroll Update Timing Sequencer

This block paces a tile-based display processor one dot at a time. It counts the dot position inside a 341-dot scanline and the line number inside a 262-line frame. From these two counts it raises single-dot control strobes that tell the scroll datapath when to act. The vertical scroll component is stepped late in the visible part of a line. The horizontal components are copied from their latch just after blanking begins. On the pre-render line, every component is refreshed from the latch. The scroll arithmetic sits in a separate datapath that only consumes these strobes.

A three-state line classifier drives the strobe logic. The states are `LINE_VISIBLE` (lines 0 to 239), `LINE_VBLANK` (lines 240 to 260) and `LINE_PRERENDER` (line 261). State changes happen only when the dot counter wraps:

- **enter_blank**: `LINE_VISIBLE` to `LINE_VBLANK`, on the wrap that leaves line 239.
- **enter_prerender**: `LINE_VBLANK` to `LINE_PRERENDER`, on the wrap that leaves line 260.
- **frame_start**: `LINE_PRERENDER` to `LINE_VISIBLE`, on the wrap that leaves line 261.

At every other edge the state holds. The strobes are combinational from the registered counters, the state and the live rendering-enable input.

Top module: `scroll_seq`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the dot count is 0, the line count is 0 and all three strobes are low.
- R2: The dot count rises by one on each clock and goes from 340 back to 0.
- R3: The line count rises by one only on the edge where the dot count wraps, and goes from 261 back to 0.
- R4: `hblank_o` is high exactly when the dot count is in 256..340.
- R5: `vert_inc_o` is high exactly when the dot count is 251, the line is 0..239 or 261, and `render_en` is high.
- R6: `horiz_copy_o` is high exactly when the dot count is 257, the line is 0..239 or 261, and `render_en` is high.
- R7: `full_reload_o` is high exactly when the dot count is 304, the line is 261, and `render_en` is high.
- R8: On lines 240 to 260, no strobe is ever raised.
- R9: With `render_en` low, all strobes stay low, and the dot and line counts advance exactly as in R2 and R3.
- R10: At most one of the three strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| render_en | input | 1 | Rendering enabled; gates all strobes |
| dot_o | output | 9 | Dot position in the line, 0..340 |
| line_o | output | 9 | Line number in the frame, 0..261 |
| hblank_o | output | 1 | High during horizontal blanking dots |
| vert_inc_o | output | 1 | Step the vertical scroll component |
| horiz_copy_o | output | 1 | Copy the horizontal scroll from the latch |
| full_reload_o | output | 1 | Reload all scroll components from the latch |

## Verification
The bench walks through a full frame and into the next one. Along the way it crosses both counter wraps and all three line-class transitions. A design that wrapped the dot or line count one step early or late would put every later strobe on the wrong coordinate, and the per-cycle comparison would show it immediately.

The rendering enable is toggled at random, and is also forced high on line 261 and on the blanking lines. This separates three faults:

- strobing during vertical blanking (R8);
- missing the pre-render reload (R7);
- dropping the vertical step and horizontal copy on the pre-render line (R5, R6).

A decoder keyed on dot 256 instead of 257, or on 250 instead of 251, would raise a strobe one dot away from where it belongs.

// File: rtl/scroll_seq_pkg.sv
package scroll_seq_pkg;
    typedef enum logic [1:0] {
        LINE_VISIBLE   = 2'd0,
        LINE_VBLANK    = 2'd1,
        LINE_PRERENDER = 2'd2
    } line_kind_e;

    typedef struct packed {
        logic vert_inc;
        logic horiz_copy;
        logic full_reload;
    } strobe_t;
endpackage

// File: rtl/scroll_dot_ctr.sv
module scroll_dot_ctr #(
    parameter int DOTS  = 341,
    parameter int DOT_W = $clog2(DOTS)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [DOT_W-1:0] dot_o,
    output logic             wrap_o
);
    localparam logic [DOT_W-1:0] LAST_DOT = DOT_W'(DOTS - 1);

    assign wrap_o = (dot_o == LAST_DOT);

    always_ff @(posedge clk) begin
        if (rst)         dot_o <= '0;
        else if (wrap_o) dot_o <= '0;
        else             dot_o <= dot_o + 1'b1;
    end

    // R2: the dot count never leaves its range
    assert_dot_range_R2: assert property (@(posedge clk) disable iff (rst)
        dot_o <= LAST_DOT);
    // R2: the count steps by one below the last dot
    assert_dot_step_R2: assert property (@(posedge clk) disable iff (rst)
        (dot_o != LAST_DOT) |=> (dot_o == $past(dot_o) + 1'b1));
    // R2: the count returns to zero after the last dot
    assert_dot_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (dot_o == LAST_DOT) |=> (dot_o == '0));
endmodule

// File: rtl/scroll_line_fsm.sv
module scroll_line_fsm
    import scroll_seq_pkg::*;
#(
    parameter int LINES     = 262,
    parameter int VIS_LINES = 240,
    parameter int LINE_W    = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap_i,
    output logic [LINE_W-1:0] line_o,
    output line_kind_e        kind_o
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);
    localparam logic [LINE_W-1:0] LAST_VIS  = LINE_W'(VIS_LINES - 1);
    localparam logic [LINE_W-1:0] LAST_BLK  = LINE_W'(LINES - 2);

    line_kind_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= LINE_VISIBLE;
        else     state_q <= state_d;
    end

    // next state: transitions only at the end of a line
    always_comb begin
        state_d = state_q;
        if (wrap_i) begin
            unique case (state_q)
                LINE_VISIBLE:   if (line_o == LAST_VIS) state_d = LINE_VBLANK;
                LINE_VBLANK:    if (line_o == LAST_BLK) state_d = LINE_PRERENDER;
                LINE_PRERENDER: state_d = LINE_VISIBLE;
                default:        state_d = LINE_VISIBLE;
            endcase
        end
    end

    // line counter
    always_ff @(posedge clk) begin
        if (rst)                                  line_o <= '0;
        else if (wrap_i && line_o == LAST_LINE)   line_o <= '0;
        else if (wrap_i)                          line_o <= line_o + 1'b1;
    end

    assign kind_o = state_q;

    // R3: line count stays in range
    assert_line_range_R3: assert property (@(posedge clk) disable iff (rst)
        line_o <= LAST_LINE);
    // R3: line holds between wraps
    assert_line_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !wrap_i |=> $stable(line_o));
    // R8: classifier agrees with the line counter
    assert_kind_blank_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == LINE_VBLANK) == (line_o > LAST_VIS && line_o < LAST_LINE));
    // R7: pre-render state only on the last line
    assert_kind_pre_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == LINE_PRERENDER) == (line_o == LAST_LINE));
endmodule

// File: rtl/scroll_strobe_dec.sv
module scroll_strobe_dec
    import scroll_seq_pkg::*;
#(
    parameter int DOT_W      = 9,
    parameter int VIS_DOTS   = 256,
    parameter int VINC_DOT   = 251,
    parameter int HCOPY_DOT  = 257,
    parameter int RELOAD_DOT = 304
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DOT_W-1:0] dot_i,
    input  line_kind_e       kind_i,
    input  logic             render_en,
    output strobe_t          stb_o,
    output logic             hblank_o
);
    logic rendered_line;

    always_comb begin
        unique case (kind_i)
            LINE_VISIBLE, LINE_PRERENDER: rendered_line = 1'b1;
            default:                      rendered_line = 1'b0;
        endcase
    end

    always_comb begin
        stb_o             = '0;
        stb_o.vert_inc    = render_en && rendered_line && (dot_i == DOT_W'(VINC_DOT));
        stb_o.horiz_copy  = render_en && rendered_line && (dot_i == DOT_W'(HCOPY_DOT));
        stb_o.full_reload = render_en && (kind_i == LINE_PRERENDER)
                            && (dot_i == DOT_W'(RELOAD_DOT));
    end

    assign hblank_o = (dot_i >= DOT_W'(VIS_DOTS));

    // R10: strobes are mutually exclusive
    assert_strobe_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stb_o.vert_inc, stb_o.horiz_copy, stb_o.full_reload}));
    // R9: no strobe without rendering
    assert_strobe_gated_R9: assert property (@(posedge clk) disable iff (rst)
        !render_en |-> (stb_o == '0));
    // R8: nothing during vertical blanking
    assert_strobe_blank_R8: assert property (@(posedge clk) disable iff (rst)
        (kind_i == LINE_VBLANK) |-> (stb_o == '0));
    // R5: a strobe is a single-dot pulse
    assert_vinc_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        stb_o.vert_inc |=> !stb_o.vert_inc);
endmodule

// File: rtl/scroll_seq.sv
module scroll_seq
    import scroll_seq_pkg::*;
#(
    parameter int DOTS       = 341,
    parameter int LINES      = 262,
    parameter int VIS_LINES  = 240,
    parameter int VIS_DOTS   = 256,
    parameter int VINC_DOT   = 251,
    parameter int HCOPY_DOT  = 257,
    parameter int RELOAD_DOT = 304,
    parameter int DOT_W      = $clog2(DOTS),
    parameter int LINE_W     = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              render_en,
    output logic [DOT_W-1:0]  dot_o,
    output logic [LINE_W-1:0] line_o,
    output logic              hblank_o,
    output logic              vert_inc_o,
    output logic              horiz_copy_o,
    output logic              full_reload_o
);
    logic       wrap;
    line_kind_e kind;
    strobe_t    stb;

    scroll_dot_ctr #(.DOTS(DOTS), .DOT_W(DOT_W)) u_dot (
        .clk(clk), .rst(rst), .dot_o(dot_o), .wrap_o(wrap)
    );

    scroll_line_fsm #(.LINES(LINES), .VIS_LINES(VIS_LINES), .LINE_W(LINE_W)) u_line (
        .clk(clk), .rst(rst), .wrap_i(wrap), .line_o(line_o), .kind_o(kind)
    );

    scroll_strobe_dec #(
        .DOT_W(DOT_W), .VIS_DOTS(VIS_DOTS), .VINC_DOT(VINC_DOT),
        .HCOPY_DOT(HCOPY_DOT), .RELOAD_DOT(RELOAD_DOT)
    ) u_dec (
        .clk(clk), .rst(rst), .dot_i(dot_o), .kind_i(kind),
        .render_en(render_en), .stb_o(stb), .hblank_o(hblank_o)
    );

    assign vert_inc_o    = stb.vert_inc;
    assign horiz_copy_o  = stb.horiz_copy;
    assign full_reload_o = stb.full_reload;

    // R3: the line advances on a dot wrap
    assert_line_adv_R3: assert property (@(posedge clk) disable iff (rst)
        (wrap && line_o != LINE_W'(LINES - 1)) |=> (line_o == $past(line_o) + 1'b1));
    // R7: reload only on the final line
    assert_reload_line_R7: assert property (@(posedge clk) disable iff (rst)
        full_reload_o |-> (line_o == LINE_W'(LINES - 1)));
endmodule

// File: tb/scroll_seq_bench.sv
module scroll_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       render_en = 1'b0;
    logic [8:0] dot_o, line_o;
    logic       hblank_o, vert_inc_o, horiz_copy_o, full_reload_o;

    int vectors = 0;
    int fails   = 0;
    int m_dot   = 0;
    int m_line  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    scroll_seq u_scroll_seq (
        .clk(clk), .rst(rst), .render_en(render_en),
        .dot_o(dot_o), .line_o(line_o), .hblank_o(hblank_o),
        .vert_inc_o(vert_inc_o), .horiz_copy_o(horiz_copy_o),
        .full_reload_o(full_reload_o)
    );

    function automatic bit rendered(int ln);
        return (ln < 240) || (ln == 261);
    endfunction

    function automatic logic [2:0] exp_stb(int d, int ln, bit en);
        logic [2:0] s;
        s[2] = en && rendered(ln) && d == 251;
        s[1] = en && rendered(ln) && d == 257;
        s[0] = en && ln == 261 && d == 304;
        return s;
    endfunction

    task automatic check(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s dot=%0d line=%0d actual=%0d expected=%0d",
                     tag, m_dot, m_line, act, exp);
        end
    endtask

    task automatic check_all();
        logic [2:0] e;
        e = exp_stb(m_dot, m_line, render_en);
        check("R2 dot", int'(dot_o), m_dot);
        check("R3 line", int'(line_o), m_line);
        check("R4 hblank", int'(hblank_o), int'(m_dot >= 256));
        check("R5 vert_inc", int'(vert_inc_o), int'(e[2]));
        check("R6 horiz_copy", int'(horiz_copy_o), int'(e[1]));
        check("R7 full_reload", int'(full_reload_o), int'(e[0]));
        if (m_line >= 240 && m_line <= 260)
            check("R8 blank quiet", int'({vert_inc_o, horiz_copy_o, full_reload_o}), 0);
        if (!render_en)
            check("R9 gated", int'({vert_inc_o, horiz_copy_o, full_reload_o}), 0);
        check("R10 onehot", int'($countones({vert_inc_o, horiz_copy_o, full_reload_o}) <= 1), 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        seed = 32'h5C0F;
        void'($urandom(seed));
        render_en = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: state held in reset
        check("R1 reset dot", int'(dot_o), 0);
        check("R1 reset line", int'(line_o), 0);
        check("R1 reset strobes", int'({vert_inc_o, horiz_copy_o, full_reload_o}), 0);
        rst = 1'b0;
        m_dot  = 0;
        m_line = 0;
        for (int cyc = 0; cyc < 262 * 341 + 2 * 341; cyc++) begin
            // mixed stimulus: random toggles, directed high on key lines
            if (m_line >= 240 && m_line <= 261)          render_en = 1'b1;
            else if (m_line == 5)                        render_en = 1'b0;
            else if (($urandom % 300) == 0)              render_en = ~render_en;
            #1;
            if (cyc == 0) begin
                // R1: first cycle after reset
                check("R1 post dot", int'(dot_o), 0);
                check("R1 post strobes", int'({vert_inc_o, horiz_copy_o, full_reload_o}), 0);
            end
            check_all();
            @(posedge clk);
            if (m_dot == 340) begin
                m_dot  = 0;
                m_line = (m_line == 261) ? 0 : m_line + 1;
            end else begin
                m_dot++;
            end
            @(negedge clk);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule